// File: doc/BRIEF.md
# SPI EEPROM Page-Write Controller

This block is the write side of a serial EEPROM slave on an SPI link. It watches the serial clock, the active-low chip select and the serial input in the system clock domain. It decodes four commands: set write enable, write data, read status and write status. For a write it takes a 16-bit address and then any number of data bytes, and it collects them into a 128-byte page buffer. The low seven address bits step after every byte and wrap inside the page, so the page number never changes.

When chip select goes high after at least one whole data byte, the block enters a programming cycle of fixed length. During that cycle it moves the buffered bytes into an on-chip storage array. While the cycle runs it answers only the status read, so a host can poll the busy flag. When the cycle ends, the write-enable latch clears.

A status bit redirects writes to a separate 128-byte identification page. Such a write is refused when the page is locked, when the whole space is protected, or when the supplied address lies in the protected region. A plain read port on the array lets the surrounding logic inspect what was stored.

Top module: `spiEepromWriter`

## Requirements
- R1: A write is opcode 0x02, then a 16-bit address, then data bytes, all MSB first and sampled on rising serial-clock edges. It is acted on only if the write-enable latch was set when the opcode arrived. Otherwise nothing is stored and no programming cycle starts.
- R2: Opcode 0x06 sets the write-enable latch when chip select rises. Opcode 0x05 returns the status byte MSB first and repeats it for as long as clocks continue. The status byte holds busy in bit 0, the write-enable latch in bit 1, block-protect in bits 3..2, lock in bit 4, ID-page enable in bit 5, and zeros in bits 7..6. misoEn is 1 only while status bits are being returned and is 0 throughout a write command.
- R3: After each data byte the address offset (bits 6..0) increments and the page bits stay fixed. Past offset 127, loading wraps to offset 0 of the same page and overwrites earlier bytes. The last byte loaded for an offset is the one stored.
- R4: The programming cycle starts when chip select rises at the end of an accepted write with at least one whole data byte. Busy reads 1 for PROG_CYCLES clocks. At the end, busy and the write-enable latch both read 0. Only offsets loaded in that command change in the array.
- R5: While busy, every opcode except 0x05 is ignored, including set write enable, write and write status. The status read still works during this time.
- R6: A partial byte before chip select rises is discarded. A write with no complete data byte starts no programming cycle and leaves the write-enable latch set.
- R7: Opcode 0x01 with the write-enable latch set takes one data byte. Its bits 3..2 become block-protect, bit 4 becomes lock and bit 5 becomes ID-page enable. The new values apply when chip select rises, and the latch clears at the same time. Without the latch, the command changes nothing.
- R8: With ID-page enable set, a write stores into the identification page at offset address[6:0] and leaves the main array unchanged.
- R9: An ID-page write is refused if lock is 1, if block-protect is 11, or if the address is in the protected region (01: address at or above 0xC000; 10: address at or above 0x8000). A refused write starts no cycle and leaves the write-enable latch set.
- R10: Serial mode 0 (clock idle low) and mode 3 (clock idle high) both work for every command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial status data to the host |
| misoEn | output | 1 | Output enable for miso; 0 means high impedance |
| memSel | input | 1 | Array read port select: 0 main array, 1 identification page |
| memAddr | input | MEM_AW | Array read port address (low 7 bits for the ID page) |
| memData | output | 8 | Array read port data, combinational |

## Verification
The hardest case to reach is a command that arrives during a programming cycle while the write-enable latch is still set. If the block failed to ignore it, that command would succeed. To create this case, the bench makes the programming cycle long. It then issues set write enable, a full write to a fresh address and a status write immediately after an accepted write, before polling for ready. Afterwards it checks the target address, the latch and the configuration bits. The ID-page refusals need the status register set up in advance through the status-write command. The bench therefore steps through lock, full protection and quarter protection, using one address inside and one outside the protected region.

// File: rtl/spiEepromPkg.sv
package spiEepromPkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;

  // configuration nibble: {idEnable, lock, protect[1:0]}
  localparam int CFG_ID = 3;
  localparam int CFG_LOCK = 2;

  typedef struct packed {
    logic clrValid;
    logic addrHiLd;
    logic addrLoLd;
    logic bufWe;
    logic statLoad;
    logic statOut;
    logic commitWe;
    logic commitId;
  } ctlStrobe_t;

endpackage

// File: rtl/spiEdgeSync.sv
module spiEdgeSync (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic mosiIn,
  output logic sckRise,
  output logic sckFall,
  output logic csActive,
  output logic csFall,
  output logic csRise,
  output logic mosiS
);

  logic [2:0] sckQ;
  logic [2:0] csQ;
  logic [1:0] mosiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ  <= '0;
      csQ   <= '1;
      mosiQ <= '0;
    end else begin
      sckQ  <= {sckQ[1:0], sckIn};
      csQ   <= {csQ[1:0], csNIn};
      mosiQ <= {mosiQ[0], mosiIn};
    end
  end

  assign sckRise  = sckQ[1] & ~sckQ[2];
  assign sckFall  = ~sckQ[1] & sckQ[2];
  assign csActive = ~csQ[1];
  assign csFall   = ~csQ[1] & csQ[2];
  assign csRise   = csQ[1] & ~csQ[2];
  assign mosiS    = mosiQ[1];

endmodule

// File: rtl/spiEepromCtl.sv
module spiEepromCtl
  import spiEepromPkg::*;
#(
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 200,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteStrobe,
  input  logic [BYTE_W-1:0] newByte,
  input  logic              csFall,
  input  logic              csRise,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        st,
  output logic [BYTE_W-1:0] statusByte,
  output logic [OFF_W-1:0]  commitIdx,
  output logic              busy,
  output logic              wel,
  output logic [3:0]        cfg
);

  typedef enum logic [3:0] {
    S_IDLE, S_OPC, S_AHI, S_ALO, S_DATA, S_STAT, S_WRSR, S_WRSR_END, S_WREN_END
  } ctlState_t;

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] QUARTER_BASE = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

  ctlState_t       state;
  logic            gotData;
  logic            commitTgt;
  logic [3:0]      pendCfg;
  logic [CNT_W-1:0] progCnt;
  logic            inProt;
  logic            idAllowed;

  always_comb begin
    case (cfg[1:0])
      2'b01:   inProt = (addr >= QUARTER_BASE);
      2'b10:   inProt = (addr >= HALF_BASE);
      2'b11:   inProt = 1'b1;
      default: inProt = 1'b0;
    endcase
  end

  assign idAllowed  = !cfg[CFG_ID] || !(cfg[CFG_LOCK] || inProt);
  assign statusByte = {2'b00, cfg, wel, busy};
  assign commitIdx  = progCnt[OFF_W-1:0];

  always_comb begin
    st          = '0;
    st.statOut  = (state == S_STAT);
    st.commitWe = busy && (progCnt < PAGE_CNT);
    st.commitId = commitTgt;
    if (byteStrobe) begin
      case (state)
        S_OPC: begin
          if (newByte == OP_RDSR) st.statLoad = 1'b1;
          else if (!busy && wel && newByte == OP_WRITE) st.clrValid = 1'b1;
        end
        S_AHI:  st.addrHiLd = 1'b1;
        S_ALO:  st.addrLoLd = 1'b1;
        S_DATA: st.bufWe = 1'b1;
        S_STAT: st.statLoad = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      gotData   <= 1'b0;
      wel       <= 1'b0;
      busy      <= 1'b0;
      cfg       <= '0;
      pendCfg   <= '0;
      progCnt   <= '0;
      commitTgt <= 1'b0;
    end else begin
      if (busy) begin
        if (progCnt == LAST_CNT) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else begin
          progCnt <= progCnt + CNT_W'(1);
        end
      end
      if (csFall) begin
        state   <= S_OPC;
        gotData <= 1'b0;
      end else if (csRise) begin
        case (state)
          S_WREN_END: wel <= 1'b1;
          S_WRSR_END: begin
            cfg <= pendCfg;
            wel <= 1'b0;
          end
          S_DATA: begin
            if (gotData && idAllowed) begin
              busy      <= 1'b1;
              progCnt   <= '0;
              commitTgt <= cfg[CFG_ID];
            end
          end
          default: ;
        endcase
        state <= S_IDLE;
      end else if (byteStrobe) begin
        case (state)
          S_OPC: begin
            if (newByte == OP_RDSR) state <= S_STAT;
            else if (busy) state <= S_IDLE;
            else begin
              case (newByte)
                OP_WREN:  state <= S_WREN_END;
                OP_WRITE: state <= wel ? S_AHI : S_IDLE;
                OP_WRSR:  state <= wel ? S_WRSR : S_IDLE;
                default:  state <= S_IDLE;
              endcase
            end
          end
          S_AHI:  state <= S_ALO;
          S_ALO:  state <= S_DATA;
          S_DATA: gotData <= 1'b1;
          S_WRSR: begin
            pendCfg <= newByte[5:2];
            state   <= S_WRSR_END;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spiEepromDp.sv
module spiEepromDp
  import spiEepromPkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int MEM_BYTES  = 1024,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int MEM_AW = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        st,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic              csActive,
  input  logic              mosiS,
  input  logic [BYTE_W-1:0] statusByte,
  input  logic [OFF_W-1:0]  commitIdx,
  input  logic              memSel,
  input  logic [MEM_AW-1:0] memAddr,
  output logic              byteStrobe,
  output logic [BYTE_W-1:0] newByte,
  output logic [ADDR_W-1:0] addr,
  output logic              miso,
  output logic              misoEn,
  output logic              memWe,
  output logic [BYTE_W-1:0] memData
);

  logic [2:0]            bitCnt;
  logic [BYTE_W-1:0]     shReg;
  logic [BYTE_W-1:0]     statShift;
  logic [PAGE_BYTES-1:0] valid;
  logic [BYTE_W-1:0]     pageBuf [PAGE_BYTES];
  logic [BYTE_W-1:0]     mainMem [MEM_BYTES];
  logic [BYTE_W-1:0]     idMem [PAGE_BYTES];
  logic [MEM_AW-1:0]     commitAddr;

  assign byteStrobe = sckRise && csActive && (bitCnt == 3'd7);
  assign newByte    = {shReg[BYTE_W-2:0], mosiS};
  assign memWe      = st.commitWe && valid[commitIdx];
  assign commitAddr = {addr[MEM_AW-1:OFF_W], commitIdx};
  assign misoEn     = st.statOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
    end else if (!csActive) begin
      bitCnt <= '0;
    end else if (sckRise) begin
      bitCnt <= bitCnt + 3'd1;
      shReg  <= newByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr  <= '0;
      valid <= '0;
    end else begin
      if (st.clrValid) valid <= '0;
      if (st.addrHiLd) addr[ADDR_W-1:BYTE_W] <= newByte;
      if (st.addrLoLd) addr[BYTE_W-1:0] <= newByte;
      if (st.bufWe) begin
        valid[addr[OFF_W-1:0]] <= 1'b1;
        addr[OFF_W-1:0] <= addr[OFF_W-1:0] + OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.bufWe) pageBuf[addr[OFF_W-1:0]] <= newByte;
  end

  always_ff @(posedge clk) begin
    if (memWe) begin
      if (st.commitId) idMem[commitIdx] <= pageBuf[commitIdx];
      else mainMem[commitAddr] <= pageBuf[commitIdx];
    end
  end

  assign memData = memSel ? idMem[memAddr[OFF_W-1:0]] : mainMem[memAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statShift <= '0;
      miso      <= 1'b0;
    end else if (st.statLoad) begin
      statShift <= statusByte;
    end else if (!st.statOut) begin
      miso <= 1'b0;
    end else if (sckFall) begin
      miso      <= statShift[BYTE_W-1];
      statShift <= {statShift[BYTE_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/spiEepromWriter.sv
module spiEepromWriter
  import spiEepromPkg::*;
#(
  parameter int PAGE_BYTES  = 128,
  parameter int MEM_BYTES   = 1024,
  parameter int PROG_CYCLES = 200,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int MEM_AW = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  output logic              misoEn,
  input  logic              memSel,
  input  logic [MEM_AW-1:0] memAddr,
  output logic [BYTE_W-1:0] memData
);

  ctlStrobe_t        st;
  logic              sckRise, sckFall, csActive, csFall, csRise, mosiS;
  logic              byteStrobe, busy, wel, memWe;
  logic [BYTE_W-1:0] newByte, statusByte;
  logic [ADDR_W-1:0] addr;
  logic [OFF_W-1:0]  commitIdx;
  logic [3:0]        cfg;

  spiEdgeSync i_sync (
    .clk(clk), .rstN(rstN), .sckIn(sck), .csNIn(csN), .mosiIn(mosi),
    .sckRise(sckRise), .sckFall(sckFall), .csActive(csActive),
    .csFall(csFall), .csRise(csRise), .mosiS(mosiS)
  );

  spiEepromCtl #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) i_ctl (
    .clk(clk), .rstN(rstN), .byteStrobe(byteStrobe), .newByte(newByte),
    .csFall(csFall), .csRise(csRise), .addr(addr), .st(st),
    .statusByte(statusByte), .commitIdx(commitIdx), .busy(busy), .wel(wel),
    .cfg(cfg)
  );

  spiEepromDp #(.PAGE_BYTES(PAGE_BYTES), .MEM_BYTES(MEM_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .sckRise(sckRise), .sckFall(sckFall),
    .csActive(csActive), .mosiS(mosiS), .statusByte(statusByte),
    .commitIdx(commitIdx), .memSel(memSel), .memAddr(memAddr),
    .byteStrobe(byteStrobe), .newByte(newByte), .addr(addr), .miso(miso),
    .misoEn(misoEn), .memWe(memWe), .memData(memData)
  );

endmodule

// File: rtl/spiEepromChk.sv
module spiEepromChk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       wel,
  input logic       memWe,
  input logic       misoEn,
  input logic       csActive,
  input logic [3:0] cfg
);

  // R4
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  // R1
  start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel));

  // R4
  commit_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R5
  wren_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> !busy);

  // R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cfg));

  // R2
  miso_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    misoEn |-> $past(csActive));

endmodule

bind spiEepromWriter spiEepromChk i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .wel(wel), .memWe(memWe),
  .misoEn(misoEn), .csActive(csActive), .cfg(cfg)
);

// File: tb/test_spiEepromWriter.sv
module test_spiEepromWriter;

  localparam int MEM_AW = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic memSel = 1'b0;
  logic [MEM_AW-1:0] memAddr = '0;
  logic miso, misoEn;
  logic [7:0] memData;

  int checks = 0;
  int failures = 0;
  bit mode3 = 1'b0;
  bit sawEn = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spiEepromWriter #(.PAGE_BYTES(128), .MEM_BYTES(1024), .PROG_CYCLES(3000)) i_spiEepromWriter (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .misoEn(misoEn), .memSel(memSel), .memAddr(memAddr), .memData(memData)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csLow();
    sck = mode3;
    idle(HALF);
    csN = 1'b0;
    idle(HALF);
  endtask

  task automatic csHigh();
    idle(HALF);
    csN = 1'b1;
    idle(4 * HALF);
  endtask

  task automatic xferBit(input logic b, output logic r);
    if (!mode3) begin
      mosi = b;
      idle(HALF);
      r = miso;
      if (misoEn) sawEn = 1'b1;
      sck = 1'b1;
      idle(HALF);
      sck = 1'b0;
    end else begin
      sck = 1'b0;
      mosi = b;
      idle(HALF);
      r = miso;
      if (misoEn) sawEn = 1'b1;
      sck = 1'b1;
      idle(HALF);
    end
  endtask

  task automatic xferByte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xferBit(b[i], r[i]);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    csLow();
    xferByte(op, d);
    csHigh();
  endtask

  task automatic cmd2(input logic [7:0] op, input logic [7:0] v);
    logic [7:0] d;
    csLow();
    xferByte(op, d);
    xferByte(v, d);
    csHigh();
  endtask

  task automatic readStatus(output logic [7:0] s);
    logic [7:0] d;
    csLow();
    xferByte(8'h05, d);
    xferByte(8'h00, s);
    csHigh();
  endtask

  task automatic writeCmd(input logic [15:0] a, input int n, input logic [7:0] base,
                          input int partial);
    logic [7:0] d;
    logic r;
    sawEn = 1'b0;
    csLow();
    xferByte(8'h02, d);
    xferByte(a[15:8], d);
    xferByte(a[7:0], d);
    for (int k = 0; k < n; k++) xferByte(base + 8'(k), d);
    for (int k = 0; k < partial; k++) xferBit(1'b1, r);
    csHigh();
  endtask

  task automatic waitReady();
    logic [7:0] s;
    for (int k = 0; k < 60; k++) begin
      readStatus(s);
      if (!s[0]) return;
    end
    chk("R4 ready timeout", 1, 0);
  endtask

  task automatic peek(input logic sel, input logic [15:0] a, output logic [7:0] d);
    memSel = sel;
    memAddr = a[MEM_AW-1:0];
    idle(1);
    d = memData;
  endtask

  task automatic testReset();
    logic [7:0] s;
    chk("R2 misoEn after reset", int'(misoEn), 0);
    readStatus(s);
    chk("R2 reset status", int'(s), 8'h00);
  endtask

  task automatic testNoWel();
    logic [7:0] b, a, s;
    peek(1'b0, 16'h0010, b);
    writeCmd(16'h0010, 1, 8'hA5, 0);
    readStatus(s);
    chk("R1 no cycle without latch", int'(s), 8'h00);
    peek(1'b0, 16'h0010, a);
    chk("R1 array untouched without latch", int'(a), int'(b));
  endtask

  task automatic testByteWrite();
    logic [7:0] s, d;
    cmd1(8'h06);
    readStatus(s);
    chk("R2 latch set by 0x06", int'(s), 8'h02);
    writeCmd(16'h0020, 1, 8'h3C, 0);
    chk("R2 misoEn low in write", int'(sawEn), 0);
    readStatus(s);
    chk("R4 busy after cs rise", int'(s[0]), 1);
    waitReady();
    readStatus(s);
    chk("R4 latch cleared after cycle", int'(s), 8'h00);
    peek(1'b0, 16'h0020, d);
    chk("R1 byte stored", int'(d), 8'h3C);
  endtask

  task automatic testPageWrap();
    logic [7:0] b180, b150, d;
    peek(1'b0, 16'h0180, b180);
    peek(1'b0, 16'h0150, b150);
    cmd1(8'h06);
    writeCmd(16'h0178, 10, 8'h40, 0);
    waitReady();
    peek(1'b0, 16'h0178, d);
    chk("R3 first offset", int'(d), 8'h40);
    peek(1'b0, 16'h017F, d);
    chk("R3 last offset of page", int'(d), 8'h47);
    peek(1'b0, 16'h0100, d);
    chk("R3 wrap to offset 0", int'(d), 8'h48);
    peek(1'b0, 16'h0101, d);
    chk("R3 wrap offset 1", int'(d), 8'h49);
    peek(1'b0, 16'h0180, d);
    chk("R3 next page untouched", int'(d), int'(b180));
    peek(1'b0, 16'h0150, d);
    chk("R4 unloaded offset untouched", int'(d), int'(b150));
  endtask

  task automatic testOverwrite();
    logic [7:0] d;
    cmd1(8'h06);
    writeCmd(16'h0200, 130, 8'h80, 0);
    waitReady();
    peek(1'b0, 16'h0200, d);
    chk("R3 overwrite offset 0", int'(d), 8'h00);
    peek(1'b0, 16'h0201, d);
    chk("R3 overwrite offset 1", int'(d), 8'h01);
    peek(1'b0, 16'h0202, d);
    chk("R3 offset 2 first pass", int'(d), 8'h82);
  endtask

  task automatic testBusyIgnore();
    logic [7:0] b40, s, d;
    peek(1'b0, 16'h0040, b40);
    cmd1(8'h06);
    writeCmd(16'h0030, 1, 8'h11, 0);
    cmd1(8'h06);
    writeCmd(16'h0040, 1, 8'h22, 0);
    cmd2(8'h01, 8'h3C);
    readStatus(s);
    chk("R5 status read while busy", int'(s), 8'h03);
    waitReady();
    readStatus(s);
    chk("R5 commands ignored while busy", int'(s), 8'h00);
    peek(1'b0, 16'h0040, d);
    chk("R5 write while busy dropped", int'(d), int'(b40));
    peek(1'b0, 16'h0030, d);
    chk("R4 first write committed", int'(d), 8'h11);
  endtask

  task automatic testPartial();
    logic [7:0] s, d, b61;
    cmd1(8'h06);
    writeCmd(16'h0050, 0, 8'h00, 5);
    readStatus(s);
    chk("R6 no whole byte keeps latch", int'(s), 8'h02);
    peek(1'b0, 16'h0061, b61);
    writeCmd(16'h0060, 1, 8'h5A, 4);
    waitReady();
    peek(1'b0, 16'h0060, d);
    chk("R6 whole byte kept", int'(d), 8'h5A);
    peek(1'b0, 16'h0061, d);
    chk("R6 partial byte dropped", int'(d), int'(b61));
  endtask

  task automatic testMode3();
    logic [7:0] s, d;
    mode3 = 1'b1;
    cmd1(8'h06);
    readStatus(s);
    chk("R10 mode 3 latch set", int'(s), 8'h02);
    writeCmd(16'h0070, 1, 8'h96, 0);
    chk("R10 mode 3 misoEn low in write", int'(sawEn), 0);
    waitReady();
    peek(1'b0, 16'h0070, d);
    chk("R10 mode 3 byte stored", int'(d), 8'h96);
    mode3 = 1'b0;
  endtask

  task automatic testStatusWrite();
    logic [7:0] s;
    cmd2(8'h01, 8'h3C);
    readStatus(s);
    chk("R7 status write needs latch", int'(s), 8'h00);
    cmd1(8'h06);
    cmd2(8'h01, 8'h20);
    readStatus(s);
    chk("R7 status write applied", int'(s), 8'h20);
  endtask

  task automatic testIdPage();
    logic [7:0] bMain, d;
    peek(1'b0, 16'hFF05, bMain);
    cmd1(8'h06);
    writeCmd(16'hFF05, 1, 8'h77, 0);
    waitReady();
    peek(1'b1, 16'h0005, d);
    chk("R8 ID page byte stored", int'(d), 8'h77);
    peek(1'b0, 16'hFF05, d);
    chk("R8 main array untouched", int'(d), int'(bMain));
  endtask

  task automatic testIdReject();
    logic [7:0] s, b6, b7, b8, b9, d;
    peek(1'b1, 16'h0006, b6);
    peek(1'b1, 16'h0007, b7);
    peek(1'b1, 16'h0008, b8);
    peek(1'b1, 16'h0009, b9);
    cmd1(8'h06);
    cmd2(8'h01, 8'h30);
    cmd1(8'h06);
    writeCmd(16'h0006, 1, 8'h99, 0);
    readStatus(s);
    chk("R9 lock refuses", int'(s), 8'h32);
    peek(1'b1, 16'h0006, d);
    chk("R9 lock leaves page", int'(d), int'(b6));
    cmd2(8'h01, 8'h2C);
    cmd1(8'h06);
    writeCmd(16'h0007, 1, 8'h98, 0);
    readStatus(s);
    chk("R9 full protect refuses", int'(s), 8'h2E);
    peek(1'b1, 16'h0007, d);
    chk("R9 full protect leaves page", int'(d), int'(b7));
    cmd2(8'h01, 8'h24);
    cmd1(8'h06);
    writeCmd(16'hC008, 1, 8'h12, 0);
    readStatus(s);
    chk("R9 quarter region refuses", int'(s), 8'h26);
    peek(1'b1, 16'h0008, d);
    chk("R9 quarter region leaves page", int'(d), int'(b8));
    writeCmd(16'h4008, 1, 8'h34, 0);
    waitReady();
    peek(1'b1, 16'h0008, d);
    chk("R9 outside region accepted", int'(d), 8'h34);
    cmd1(8'h06);
    cmd2(8'h01, 8'h28);
    cmd1(8'h06);
    writeCmd(16'h8009, 1, 8'h56, 0);
    readStatus(s);
    chk("R9 half region refuses", int'(s), 8'h2A);
    peek(1'b1, 16'h0009, d);
    chk("R9 half region leaves page", int'(d), int'(b9));
  endtask

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(5);
    testReset();
    testNoWel();
    testByteWrite();
    testPageWrap();
    testOverwrite();
    testBusyIgnore();
    testPartial();
    testMode3();
    testStatusWrite();
    testIdPage();
    testIdReject();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule